// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits between several processor request ports and a shared memory. It decides whether each exclusive store may reach memory. A load-exclusive leaves a mark for the port that issued it. For a shareable access the mark is the address granule. For a non-shareable access the mark is a simple per-port flag. A later store-exclusive from the same port succeeds only if its mark is still intact. The block then raises that port's write enable toward memory and returns a status bit: 0 for success and 1 for failure. Software repeats its load-exclusive / store-exclusive sequence until it sees 0.

The monitor watches every store that reaches memory. A shareable write from one port removes the matching reservations held by the other ports. When two ports race for the same granule in one cycle, a fixed priority settles it: the lower port index wins. A per-port clear input and the asynchronous reset drop the marks. Decisions are combinational in the request cycle. The marks change at the following clock edge.

Top module: `excl_mon`

## Requirements
- R1: A load-exclusive to a shareable, aligned address reserves that address's granule for the issuing port. Any reservation the port held on another granule is dropped, so a later store-exclusive to the old granule fails.
- R2: A load-exclusive to a non-shareable, aligned address sets the port's pending flag and does not compare addresses. A non-shareable store-exclusive succeeds exactly when the flag is set, whatever its address. Success or failure clears the flag.
- R3: A shareable store-exclusive whose granule matches the port's live reservation raises `mem_we` for that port and reports status 0 in the same cycle. The reservation is then cleared, so an immediate repeat fails.
- R4: A shareable store-exclusive with no reservation, or with a reservation on a different granule, reports status 1 and leaves `mem_we` low. The port's reservation is cleared either way.
- R5: The granule is the address with its low `GRAN_LG` bits ignored (8 bytes by default). Any naturally aligned access inside the reserved granule matches. The `req_size` encoding is 0 = byte, 1 = halfword, 2 = word, 3 = doubleword (8 bytes, two data words at one address).
- R6: An exclusive access whose address is not aligned to its size is treated as follows. A misaligned store-exclusive fails with no write and clears the mark it would have used. A misaligned load-exclusive clears both the port's reservation and its pending flag.
- R7: A shareable write that reaches memory clears the reservation of every other port whose reserved granule matches. Such a write is either a plain store or a successful store-exclusive. A same-cycle shareable load-exclusive by another port to that granule is also left unreserved. The writer's own reservation and all non-shareable writes are unaffected.
- R8: When several ports write the same shareable granule in one cycle, they are ordered by index, lowest first. A store-exclusive is refused if a lower-index port writes that granule in the same cycle. So of two racing store-exclusives only the lowest-index one succeeds. The loser gets status 1 and its reservation is gone.
- R9: A high `clrex` bit drops that port's reservation and pending flag. It takes precedence over that port's request in the same cycle, and a store-exclusive in that cycle fails. Reset clears every port's marks.
- R10: A plain store (op 1) always raises its port's `mem_we` with no status. Loads (op 0 and op 2) never raise `mem_we`. `st_resp_valid` is high only for a store-exclusive (op 3). The `req_op` encoding is 0 = load, 1 = store, 2 = load-exclusive, 3 = store-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORTS | Request present, one bit per port |
| req_op | input | 2*NPORTS | Operation per port, 2 bits each (R10 encoding) |
| req_addr | input | AW*NPORTS | Byte address per port, AW bits each |
| req_size | input | 2*NPORTS | Access size per port, 2 bits each (R5 encoding) |
| req_shared | input | NPORTS | Shareable attribute per port |
| clrex | input | NPORTS | Per-port clear of reservation and pending flag |
| mem_we | output | NPORTS | Write allowed to memory, one bit per port, same cycle |
| st_resp_valid | output | NPORTS | Store-exclusive status present, same cycle |
| st_resp_fail | output | NPORTS | Store-exclusive status: 0 success, 1 failure |

## Verification
The directed scenarios aim at the places where a monitor usually slips. A design that compared the full address instead of the granule would fail a word store inside a doubleword reservation. A design that kept a reservation after a success or a mismatch would let a second store-exclusive through. A design that left other ports' reservations intact after a shareable plain store would let a stale read-modify-write overwrite newer data. The bench also races two store-exclusives to one granule to catch double winners or a reversed priority. It checks that a clear request beats a same-cycle load-exclusive, and that a misaligned exclusive neither writes nor leaves a usable mark.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    OP_LD  = 2'd0,
    OP_ST  = 2'd1,
    OP_LDX = 2'd2,
    OP_STX = 2'd3
  } xop_e;

  // natural alignment of an access of 1, 2, 4 or 8 bytes
  function automatic logic size_aligned(input logic [2:0] lo, input logic [1:0] sz);
    logic ok;
    case (sz)
      2'd0:    ok = 1'b1;
      2'd1:    ok = (lo[0] == 1'b0);
      2'd2:    ok = (lo[1:0] == 2'b00);
      default: ok = (lo == 3'b000);
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/excl_mon_entry.sv
// Per-port reservation state: granule reservation plus non-shareable pending flag.
module excl_mon_entry #(
  parameter int GW = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          req_ldx,
  input  logic          req_stx,
  input  logic          aligned,
  input  logic          shared,
  input  logic [GW-1:0] gran,
  input  logic          kill_new,
  input  logic          kill_held,
  output logic          res_valid,
  output logic [GW-1:0] res_gran,
  output logic          pend,
  output logic          hit
);

  logic          res_valid_nxt;
  logic [GW-1:0] res_gran_nxt;
  logic          pend_nxt;
  logic          upd_en;

  // store-exclusive is eligible on this port's own state
  assign hit = req_stx & ~clr & aligned &
               (shared ? (res_valid & (res_gran == gran)) : pend);

  assign upd_en = clr | req_ldx | req_stx | kill_held;

  always_comb begin
    res_valid_nxt = res_valid & ~kill_held;
    res_gran_nxt  = res_gran;
    pend_nxt      = pend;
    if (clr) begin
      res_valid_nxt = 1'b0;
      pend_nxt      = 1'b0;
    end else if (req_ldx) begin
      if (!aligned) begin
        res_valid_nxt = 1'b0;
        pend_nxt      = 1'b0;
      end else if (shared) begin
        res_valid_nxt = ~kill_new;
        res_gran_nxt  = gran;
      end else begin
        pend_nxt = 1'b1;
      end
    end else if (req_stx) begin
      if (shared) res_valid_nxt = 1'b0;
      else        pend_nxt      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_gran  <= '0;
      pend      <= 1'b0;
    end else if (upd_en) begin
      res_valid <= res_valid_nxt;
      res_gran  <= res_gran_nxt;
      pend      <= pend_nxt;
    end
  end

endmodule

// File: rtl/excl_mon_order.sv
// Orders same-cycle writes by port index and derives cross-port reservation kills.
module excl_mon_order #(
  parameter int NP = 4,
  parameter int GW = 29
) (
  input  logic [NP-1:0] st_plain,
  input  logic [NP-1:0] hit,
  input  logic [NP-1:0] shared,
  input  logic [GW-1:0] gran      [NP],
  input  logic [NP-1:0] res_valid,
  input  logic [GW-1:0] res_gran  [NP],
  output logic [NP-1:0] wr,
  output logic [NP-1:0] kill_new,
  output logic [NP-1:0] kill_held
);

  logic [NP-1:0] snoop;

  // a port's write is visible to the rest only when it is shareable
  assign snoop = wr & shared;

  always_comb begin
    wr = '0;
    for (int i = 0; i < NP; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < NP; j++) begin
        if (j < i && snoop[j] && (gran[j] == gran[i])) blk = 1'b1;
      end
      wr[i] = st_plain[i] | (hit[i] & ~(blk & shared[i]));
    end
  end

  always_comb begin
    kill_new  = '0;
    kill_held = '0;
    for (int i = 0; i < NP; i++) begin
      for (int j = 0; j < NP; j++) begin
        if (j != i && snoop[j]) begin
          if (gran[j] == gran[i]) kill_new[i] = 1'b1;
          if (res_valid[i] && (gran[j] == res_gran[i])) kill_held[i] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/excl_mon.sv
module excl_mon #(
  parameter int NPORTS  = 4,
  parameter int AW      = 32,
  parameter int GRAN_LG = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    req_valid,
  input  logic [2*NPORTS-1:0]  req_op,
  input  logic [AW*NPORTS-1:0] req_addr,
  input  logic [2*NPORTS-1:0]  req_size,
  input  logic [NPORTS-1:0]    req_shared,
  input  logic [NPORTS-1:0]    clrex,
  output logic [NPORTS-1:0]    mem_we,
  output logic [NPORTS-1:0]    st_resp_valid,
  output logic [NPORTS-1:0]    st_resp_fail
);
  import excl_mon_pkg::*;

  localparam int GW = AW - GRAN_LG;

  logic [NPORTS-1:0] is_ld_x;
  logic [NPORTS-1:0] is_st_x;
  logic [NPORTS-1:0] is_st;
  logic [NPORTS-1:0] aligned;
  logic [NPORTS-1:0] hit;
  logic [NPORTS-1:0] wr;
  logic [NPORTS-1:0] kill_new;
  logic [NPORTS-1:0] kill_held;
  logic [NPORTS-1:0] res_valid;
  logic [NPORTS-1:0] pend;
  logic [GW-1:0]     gran     [NPORTS];
  logic [GW-1:0]     res_gran [NPORTS];

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    xop_e          op_i;
    logic [AW-1:0] addr_i;

    assign op_i       = xop_e'(req_op[2*i +: 2]);
    assign addr_i     = req_addr[AW*i +: AW];
    assign is_ld_x[i] = req_valid[i] && (op_i == OP_LDX);
    assign is_st_x[i] = req_valid[i] && (op_i == OP_STX);
    assign is_st[i]   = req_valid[i] && (op_i == OP_ST);
    assign gran[i]    = addr_i[AW-1:GRAN_LG];
    assign aligned[i] = size_aligned(addr_i[2:0], req_size[2*i +: 2]);

    excl_mon_entry #(.GW(GW)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clrex[i]),
      .req_ldx   (is_ld_x[i]),
      .req_stx   (is_st_x[i]),
      .aligned   (aligned[i]),
      .shared    (req_shared[i]),
      .gran      (gran[i]),
      .kill_new  (kill_new[i]),
      .kill_held (kill_held[i]),
      .res_valid (res_valid[i]),
      .res_gran  (res_gran[i]),
      .pend      (pend[i]),
      .hit       (hit[i])
    );
  end

  excl_mon_order #(.NP(NPORTS), .GW(GW)) u_order (
    .st_plain  (is_st),
    .hit       (hit),
    .shared    (req_shared),
    .gran      (gran),
    .res_valid (res_valid),
    .res_gran  (res_gran),
    .wr        (wr),
    .kill_new  (kill_new),
    .kill_held (kill_held)
  );

  assign mem_we        = wr;
  assign st_resp_valid = is_st_x;
  assign st_resp_fail  = is_st_x & ~wr;

endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
  parameter int NPORTS  = 4,
  parameter int AW      = 32,
  parameter int GRAN_LG = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NPORTS-1:0]    req_valid,
  input logic [2*NPORTS-1:0]  req_op,
  input logic [AW*NPORTS-1:0] req_addr,
  input logic [2*NPORTS-1:0]  req_size,
  input logic [NPORTS-1:0]    req_shared,
  input logic [NPORTS-1:0]    clrex,
  input logic [NPORTS-1:0]    mem_we,
  input logic [NPORTS-1:0]    st_resp_valid,
  input logic [NPORTS-1:0]    st_resp_fail
);
  import excl_mon_pkg::*;

  logic [NPORTS-1:0] ok;
  assign ok = st_resp_valid & ~st_resp_fail;

  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    logic [AW-1:0] a_i;
    logic          mis_i;
    logic          stxq_i;
    assign a_i    = req_addr[AW*i +: AW];
    assign mis_i  = ~size_aligned(a_i[2:0], req_size[2*i +: 2]);
    assign stxq_i = req_valid[i] && (req_op[2*i +: 2] == 2'd3);

    assert_fail_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_resp_valid[i] && st_resp_fail[i]) |-> !mem_we[i]);

    assert_we_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we[i] |-> (req_valid[i] && req_op[2*i] == 1'b1));

    assert_misalign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stxq_i && mis_i) |-> (st_resp_fail[i] && !mem_we[i]));

    assert_clrex_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clrex[i] |=> !ok[i]);

    assert_no_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ok[i] && req_shared[i]) |=> !(ok[i] && req_shared[i]));

    assert_no_repeat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ok[i] && !req_shared[i]) |=> !(ok[i] && !req_shared[i]));

    for (genvar j = i + 1; j < NPORTS; j++) begin : g_pair
      assert_one_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_shared[i] && req_shared[j] &&
         req_addr[AW*i+GRAN_LG +: AW-GRAN_LG] == req_addr[AW*j+GRAN_LG +: AW-GRAN_LG])
        |-> !(ok[i] && ok[j]));
    end
  end

endmodule

bind excl_mon excl_mon_chk #(.NPORTS(NPORTS), .AW(AW), .GRAN_LG(GRAN_LG)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_op        (req_op),
  .req_addr      (req_addr),
  .req_size      (req_size),
  .req_shared    (req_shared),
  .clrex         (clrex),
  .mem_we        (mem_we),
  .st_resp_valid (st_resp_valid),
  .st_resp_fail  (st_resp_fail)
);

// File: tb/sim_excl_mon.sv
`timescale 1ns/1ps
module sim_excl_mon;
  localparam int NP = 4;
  localparam int AW = 32;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LDX = 2'd2, STX = 2'd3;
  localparam logic [1:0] SB = 2'd0, SH = 2'd1, SW = 2'd2, SD = 2'd3;

  logic clk, rst_n;
  logic [NP-1:0]    req_valid, req_shared, clrex;
  logic [2*NP-1:0]  req_op, req_size;
  logic [AW*NP-1:0] req_addr;
  logic [NP-1:0]    mem_we, st_resp_valid, st_resp_fail;
  int checks = 0;
  int errors = 0;

  excl_mon #(.NPORTS(NP), .AW(AW), .GRAN_LG(3)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_size(req_size), .req_shared(req_shared),
    .clrex(clrex), .mem_we(mem_we), .st_resp_valid(st_resp_valid),
    .st_resp_fail(st_resp_fail));

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic idle();
    req_valid = '0; req_shared = '0; clrex = '0;
    req_op = '0; req_size = '0; req_addr = '0;
  endtask

  task automatic setp(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [1:0] sz, input logic sh);
    req_valid[p]        = 1'b1;
    req_op[2*p +: 2]    = op;
    req_size[2*p +: 2]  = sz;
    req_addr[AW*p +: AW] = a;
    req_shared[p]       = sh;
  endtask

  task automatic chk(input string tag, input int p, input logic we,
                     input logic rv, input logic fl);
    checks++;
    if (mem_we[p] !== we || st_resp_valid[p] !== rv || (rv && st_resp_fail[p] !== fl)) begin
      errors++;
      $display("FAIL %s port %0d: we/rv/fail=%b/%b/%b expected %b/%b/%b",
               tag, p, mem_we[p], st_resp_valid[p], st_resp_fail[p], we, rv, fl);
    end
  endtask

  task automatic begin_cyc();
    @(negedge clk);
  endtask

  task automatic end_cyc();
    @(posedge clk);
    #1 idle();
  endtask

  task automatic op1(input string tag, input int p, input logic [1:0] op,
                     input logic [AW-1:0] a, input logic [1:0] sz, input logic sh,
                     input logic we, input logic rv, input logic fl);
    begin_cyc();
    setp(p, op, a, sz, sh);
    #1 chk(tag, p, we, rv, fl);
    end_cyc();
  endtask

  task automatic t_reset();
    for (int p = 0; p < NP; p++) begin
      #0 chk("R9 reset outputs", p, 1'b0, 1'b0, 1'b0);
    end
    op1("R9 no reservation after reset", 0, STX, 32'h100, SW, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_shared_basic();
    op1("R10 ldx no write", 0, LDX, 32'h100, SD, 1'b1, 1'b0, 1'b0, 1'b0);
    op1("R3 R5 stx word inside granule", 0, STX, 32'h104, SW, 1'b1, 1'b1, 1'b1, 1'b0);
    op1("R3 repeat fails", 0, STX, 32'h100, SD, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_replace();
    op1("R1 ldx A", 1, LDX, 32'h200, SW, 1'b1, 1'b0, 1'b0, 1'b0);
    op1("R1 ldx B", 1, LDX, 32'h300, SW, 1'b1, 1'b0, 1'b0, 1'b0);
    op1("R1 old granule fails", 1, STX, 32'h200, SW, 1'b1, 1'b0, 1'b1, 1'b1);
    op1("R4 mismatch cleared reservation", 1, STX, 32'h300, SW, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_nonshared();
    op1("R2 ldx local", 2, LDX, 32'h40, SW, 1'b0, 1'b0, 1'b0, 1'b0);
    op1("R2 stx any address", 2, STX, 32'h998, SW, 1'b0, 1'b1, 1'b1, 1'b0);
    op1("R2 flag cleared", 2, STX, 32'h40, SW, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_misalign();
    op1("R6 ldx", 0, LDX, 32'h500, SW, 1'b1, 1'b0, 1'b0, 1'b0);
    op1("R6 misaligned stx fails", 0, STX, 32'h501, SW, 1'b1, 1'b0, 1'b1, 1'b1);
    op1("R6 reservation gone", 0, STX, 32'h500, SW, 1'b1, 1'b0, 1'b1, 1'b1);
    op1("R6 ldx again", 0, LDX, 32'h500, SW, 1'b1, 1'b0, 1'b0, 1'b0);
    op1("R6 misaligned ldx", 0, LDX, 32'h503, SH, 1'b1, 1'b0, 1'b0, 1'b0);
    op1("R6 misaligned ldx dropped mark", 0, STX, 32'h500, SW, 1'b1, 1'b0, 1'b1, 1'b1);
    op1("R6 ldx byte", 0, LDX, 32'h507, SB, 1'b1, 1'b0, 1'b0, 1'b0);
    op1("R5 byte ldx then half stx", 0, STX, 32'h502, SH, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_snoop();
    begin_cyc();
    setp(0, LDX, 32'h600, SW, 1'b1);
    setp(1, LDX, 32'h600, SW, 1'b1);
    setp(2, LDX, 32'h700, SW, 1'b1);
    end_cyc();
    op1("R10 R7 plain shared store", 3, ST, 32'h604, SW, 1'b1, 1'b1, 1'b0, 1'b0);
    op1("R7 port0 reservation killed", 0, STX, 32'h600, SW, 1'b1, 1'b0, 1'b1, 1'b1);
    op1("R7 port1 reservation killed", 1, STX, 32'h600, SW, 1'b1, 1'b0, 1'b1, 1'b1);
    op1("R7 other granule kept", 2, STX, 32'h700, SW, 1'b1, 1'b1, 1'b1, 1'b0);
    op1("R7 own ldx", 0, LDX, 32'h800, SW, 1'b1, 1'b0, 1'b0, 1'b0);
    op1("R7 own plain store", 0, ST, 32'h800, SW, 1'b1, 1'b1, 1'b0, 1'b0);
    op1("R7 own store keeps reservation", 0, STX, 32'h800, SW, 1'b1, 1'b1, 1'b1, 1'b0);
    op1("R7 ldx p1", 1, LDX, 32'h900, SW, 1'b1, 1'b0, 1'b0, 1'b0);
    op1("R7 non-shared store", 2, ST, 32'h900, SW, 1'b0, 1'b1, 1'b0, 1'b0);
    op1("R7 non-shared store no kill", 1, STX, 32'h900, SW, 1'b1, 1'b1, 1'b1, 1'b0);
    // same-cycle ldx versus another port's shared write: the write wins
    begin_cyc();
    setp(1, ST, 32'hD00, SW, 1'b1);
    setp(2, LDX, 32'hD00, SW, 1'b1);
    end_cyc();
    op1("R7 same-cycle ldx left unreserved", 2, STX, 32'hD00, SW, 1'b1, 1'b0, 1'b1, 1'b1);
    op1("R10 plain load", 3, LD, 32'hD00, SW, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_contend();
    begin_cyc();
    setp(1, LDX, 32'hA00, SW, 1'b1);
    setp(2, LDX, 32'hA00, SW, 1'b1);
    end_cyc();
    begin_cyc();
    setp(1, STX, 32'hA00, SW, 1'b1);
    setp(2, STX, 32'hA04, SW, 1'b1);
    #1;
    chk("R8 lower index wins", 1, 1'b1, 1'b1, 1'b0);
    chk("R8 higher index loses", 2, 1'b0, 1'b1, 1'b1);
    end_cyc();
    op1("R8 loser reservation cleared", 2, STX, 32'hA00, SW, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_clrex();
    op1("R9 ldx shared", 3, LDX, 32'hB00, SW, 1'b1, 1'b0, 1'b0, 1'b0);
    op1("R9 ldx local", 3, LDX, 32'hB00, SW, 1'b0, 1'b0, 1'b0, 1'b0);
    begin_cyc(); clrex[3] = 1'b1; end_cyc();
    op1("R9 shared mark cleared", 3, STX, 32'hB00, SW, 1'b1, 1'b0, 1'b1, 1'b1);
    op1("R9 local flag cleared", 3, STX, 32'hB00, SW, 1'b0, 1'b0, 1'b1, 1'b1);
    begin_cyc(); clrex[3] = 1'b1; setp(3, LDX, 32'hC00, SW, 1'b1); end_cyc();
    op1("R9 clear beats ldx", 3, STX, 32'hC00, SW, 1'b1, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shared_basic();
    t_replace();
    t_nonshared();
    t_misalign();
    t_snoop();
    t_contend();
    t_clrex();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule